// File: doc/BRIEF.md
# Paged SPI Register-File Target

This block is an SPI target that gives an external host access to a bank of byte-wide registers. The bank is split into pages of 128 registers. Each transaction starts when chip select goes low. The first byte is a command: its lowest bit selects the direction and its upper seven bits give the register offset. A write then stores one data byte. A read streams out bytes from that offset and the offsets after it, for as long as the host keeps clocking. Offset 0 is not storage. It is the page selector, and it picks which page every later access reaches.

The SPI pins are sampled into the local clock domain through a synchronizer, so the serial clock must be several times slower than the local clock. A parallel backdoor port on the local clock writes and reads the storage array directly. Local logic uses it to preload values that the host will read, and to inspect values that the host has written.

Top module: `spi_paged_regfile`

## Requirements
- R1: After reset, MISO is 0, the page selector is 0, and every storage location reads 0 through the backdoor.
- R2: Bits move MSB first. MOSI is captured on the rising SCK edge. In the first byte of a transaction, bit 0 = 1 means read, bit 0 = 0 means write, and bits 7:1 are the register offset.
- R3: In a write transaction, the byte after the command is stored at backdoor index page*128 + offset.
- R4: A write to offset 0 sets the page selector to the low log2(PAGES) bits of the data byte and stores nothing in the array. Later accesses use the new page. Reading offset 0 returns the page number, zero-extended.
- R5: In a read transaction, MISO changes only after falling SCK edges. The register value appears MSB first, starting at the falling edge that ends the command byte, so that each bit is valid at the host's next rising edge.
- R6: A read keeps returning bytes from successive offsets within the current page, for 52 bytes or more. The offset wraps from 0x7F to 0x00, and offset 0x00 returns the page number.
- R7: MISO is 0 while chip select is high, during the command byte, and during write data bytes.
- R8: Releasing chip select discards any partial byte. The next byte after chip select falls is decoded as a new command, and an unfinished write data byte is not stored.
- R9: Only the first data byte after a write command is stored. Further bytes in the same transaction change nothing.
- R10: A backdoor write stores bd_wdata at bd_addr (page*128 + offset). bd_rdata shows the stored byte at bd_addr, and SPI reads return backdoor-loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| sck | input | 1 | SPI serial clock from the host (mode 0) |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data to the host |
| bd_we | input | 1 | Backdoor write strobe |
| bd_addr | input | log2(PAGES)+7 | Backdoor index, page in the upper bits |
| bd_wdata | input | 8 | Backdoor write data |
| bd_rdata | output | 8 | Backdoor read data at bd_addr |

## Verification
The bench builds the block with PAGES = 4 and SYNC_STAGES = 2. Four pages make the page selector two bits wide. Data bytes with high bits set then show that the selector is truncated, and that writes on one page leave the same offset on another page untouched. Two synchronizer stages give the shortest edge-detect latency, and an SCK half-period of eight local clocks still leaves margin. A 52-byte burst that starts at offset 0x60 crosses the 0x7F-to-0x00 wrap and reads the page selector in the middle of the stream.

// File: rtl/spi_prf_pkg.sv
package spi_prf_pkg;
   localparam int ADDR_W = 7;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      PH_CMD   = 2'd0,
      PH_WDATA = 2'd1,
      PH_RDATA = 2'd2,
      PH_SKIP  = 2'd3
   } phase_t;
endpackage

// File: rtl/spi_prf_sync.sv
module spi_prf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic mosi,
   input  logic cs_n,
   output logic sck_rise,
   output logic sck_fall,
   output logic mosi_s,
   output logic cs_act
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_prf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sck_p, mosi_p, cs_p;
   logic              sck_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_p  <= '0;
         mosi_p <= '0;
         cs_p   <= '1;
         sck_q  <= 1'b0;
      end else begin
         sck_p  <= {sck_p[STAGES-2:0], sck};
         mosi_p <= {mosi_p[STAGES-2:0], mosi};
         cs_p   <= {cs_p[STAGES-2:0], cs_n};
         sck_q  <= sck_p[STAGES-1];
      end
   end

   assign sck_rise = sck_p[STAGES-1] & ~sck_q;
   assign sck_fall = ~sck_p[STAGES-1] & sck_q;
   assign mosi_s   = mosi_p[STAGES-1];
   assign cs_act   = ~cs_p[STAGES-1];
endmodule

// File: rtl/spi_prf_shifter.sv
module spi_prf_shifter #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_act,
   input  logic          sck_rise,
   input  logic          sck_fall,
   input  logic          mosi_s,
   input  logic          tx_en,
   input  logic [DW-1:0] tx_byte,
   output logic [DW-1:0] rx_byte,
   output logic          byte_done,
   output logic          miso
);
   localparam int CW = $clog2(DW);

   generate
      if (DW < 3) begin : g_bad_dw
         $error("spi_prf_shifter: DW must be at least 3");
      end
   endgenerate

   logic [CW-1:0] bit_cnt;
   logic [DW-2:0] rx_sh;
   logic [DW-1:0] tx_sh;
   logic          miso_q;

   assign rx_byte   = {rx_sh, mosi_s};
   assign byte_done = cs_act & sck_rise & (bit_cnt == CW'(DW-1));
   assign miso      = miso_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         miso_q  <= 1'b0;
      end else if (!cs_act) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         miso_q  <= 1'b0;
      end else begin
         if (sck_rise) begin
            rx_sh   <= rx_byte[DW-2:0];
            bit_cnt <= (bit_cnt == CW'(DW-1)) ? '0 : bit_cnt + CW'(1);
         end
         if (sck_fall) begin
            if (!tx_en) begin
               miso_q <= 1'b0;
            end else if (bit_cnt == '0) begin
               miso_q <= tx_byte[DW-1];
               tx_sh  <= {tx_byte[DW-2:0], 1'b0};
            end else begin
               miso_q <= tx_sh[DW-1];
               tx_sh  <= {tx_sh[DW-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/spi_prf_bank.sv
module spi_prf_bank #(
   parameter int DW = 8,
   parameter int IW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   input  logic          bd_we,
   input  logic [IW-1:0] bd_idx,
   input  logic [DW-1:0] bd_wdata,
   output logic [DW-1:0] bd_rdata
);
   localparam int DEPTH = 1 << IW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (bd_we) mem[bd_idx] <= bd_wdata;
         if (wr_en) mem[wr_idx] <= wr_data;
      end
   end

   assign rd_data  = mem[rd_idx];
   assign bd_rdata = mem[bd_idx];
endmodule

// File: rtl/spi_paged_regfile.sv
module spi_paged_regfile
   import spi_prf_pkg::*;
#(
   parameter int PAGES       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            sck,
   input  logic                            mosi,
   input  logic                            cs_n,
   output logic                            miso,
   input  logic                            bd_we,
   input  logic [$clog2(PAGES)+ADDR_W-1:0] bd_addr,
   input  logic [BYTE_W-1:0]               bd_wdata,
   output logic [BYTE_W-1:0]               bd_rdata
);
   localparam int PW = $clog2(PAGES);
   localparam int IW = PW + ADDR_W;

   generate
      if (PAGES < 2 || (PAGES & (PAGES - 1)) != 0 || PW > BYTE_W) begin : g_bad_pages
         $error("spi_paged_regfile: PAGES must be a power of two from 2 to 256");
      end
   endgenerate

   logic              cs_act, sck_rise, sck_fall, mosi_s;
   logic [BYTE_W-1:0] rx_byte;
   logic              byte_done;
   phase_t            phase;
   logic [ADDR_W-1:0] addr_q, rd_off;
   logic [BYTE_W-1:0] tx_q, arr_rd, rd_val;
   logic [PW-1:0]     cur_page;
   logic              wr_en, page_we;

   spi_prf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck      (sck),
      .mosi     (mosi),
      .cs_n     (cs_n),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .mosi_s   (mosi_s),
      .cs_act   (cs_act)
   );

   spi_prf_shifter #(.DW(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .mosi_s    (mosi_s),
      .tx_en     (phase == PH_RDATA),
      .tx_byte   (tx_q),
      .rx_byte   (rx_byte),
      .byte_done (byte_done),
      .miso      (miso)
   );

   spi_prf_bank #(.DW(BYTE_W), .IW(IW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   ({cur_page, addr_q}),
      .wr_data  (rx_byte),
      .rd_idx   ({cur_page, rd_off}),
      .rd_data  (arr_rd),
      .bd_we    (bd_we),
      .bd_idx   (bd_addr),
      .bd_wdata (bd_wdata),
      .bd_rdata (bd_rdata)
   );

   // Offset fetched for the next outgoing byte: the command's offset, or the following one in a burst
   assign rd_off  = (phase == PH_CMD) ? rx_byte[BYTE_W-1:1] : addr_q + ADDR_W'(1);
   assign rd_val  = (rd_off == '0) ? BYTE_W'(cur_page) : arr_rd;
   assign wr_en   = byte_done && (phase == PH_WDATA) && (addr_q != '0);
   assign page_we = byte_done && (phase == PH_WDATA) && (addr_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         addr_q   <= '0;
         tx_q     <= '0;
         cur_page <= '0;
      end else begin
         if (page_we) cur_page <= rx_byte[PW-1:0];
         if (!cs_act) begin
            phase <= PH_CMD;
         end else if (byte_done) begin
            unique case (phase)
               PH_CMD: begin
                  addr_q <= rx_byte[BYTE_W-1:1];
                  phase  <= rx_byte[0] ? PH_RDATA : PH_WDATA;
                  tx_q   <= rd_val;
               end
               PH_WDATA: phase <= PH_SKIP;
               PH_RDATA: begin
                  addr_q <= addr_q + ADDR_W'(1);
                  tx_q   <= rd_val;
               end
               default: phase <= PH_SKIP;
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_paged_regfile_chk.sv
module spi_paged_regfile_chk
   import spi_prf_pkg::*;
#(
   parameter int PW = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_act,
   input logic              byte_done,
   input phase_t            phase,
   input logic [ADDR_W-1:0] addr_q,
   input logic [BYTE_W-1:0] rx_byte,
   input logic [PW-1:0]     cur_page,
   input logic              miso
);
   AST_MISO_QUIET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !miso); // R7

   AST_MISO_QUIET_NONREAD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_RDATA) |-> !miso); // R7

   AST_ABORT_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (phase == PH_CMD)); // R8

   AST_CMD_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase == PH_CMD) |=>
         (phase == ($past(rx_byte[0]) ? PH_RDATA : PH_WDATA)) &&
         (addr_q == $past(rx_byte[BYTE_W-1:1]))); // R2

   AST_PAGE_ONLY_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_page != $past(cur_page)) |->
         $past(byte_done && phase == PH_WDATA && addr_q == '0)); // R4

   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase == PH_RDATA) |=>
         (addr_q == ADDR_W'($past(addr_q) + 1'b1))); // R6

   AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase == PH_WDATA) |=> (phase != PH_WDATA)); // R9
endmodule

bind spi_paged_regfile spi_paged_regfile_chk #(.PW(PW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_act    (cs_act),
   .byte_done (byte_done),
   .phase     (phase),
   .addr_q    (addr_q),
   .rx_byte   (rx_byte),
   .cur_page  (cur_page),
   .miso      (miso)
);

// File: tb/spi_paged_regfile_tb_top.sv
`timescale 1ns/1ps
module spi_paged_regfile_tb_top;
   localparam int PAGES = 4;
   localparam int PW    = 2;
   localparam int HALF  = 8;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
   logic          miso;
   logic          bd_we = 1'b0;
   logic [PW+6:0] bd_addr = '0;
   logic [7:0]    bd_wdata = '0;
   logic [7:0]    bd_rdata;

   logic [7:0] model [PAGES*128];
   int         mpage = 0;
   int         n_tests = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   spi_paged_regfile #(.PAGES(PAGES), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso),
      .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata), .bd_rdata(bd_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input int off);
      return (off == 0) ? 8'(mpage) : model[mpage*128 + off];
   endfunction

   task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
      rx = '0;
      for (int b = 7; b >= 8 - nb; b--) begin
         @(negedge clk) mosi = tx[b];
         repeat (HALF) @(negedge clk);
         rx[b] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic sel();
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic desel();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2*HALF) @(negedge clk);
   endtask

   task automatic spi_write(input int a, input logic [7:0] d);
      logic [7:0] r;
      sel();
      xbits({7'(a), 1'b0}, 8, r);
      chk("R7", r, 0, "miso during write command");
      xbits(d, 8, r);
      chk("R7", r, 0, "miso during write data");
      desel();
      if (a == 0) mpage = int'(d) % PAGES;
      else model[mpage*128 + a] = d;
   endtask

   task automatic spi_read(input int a, input int n);
      logic [7:0] r;
      sel();
      xbits({7'(a), 1'b1}, 8, r);
      chk("R7", r, 0, "miso during read command");
      for (int i = 0; i < n; i++) begin
         xbits(8'($urandom), 8, r);
         chk(i == 0 ? "R5" : "R6", r, exp_rd((a + i) % 128), "read data");
      end
      desel();
   endtask

   task automatic bd_write(input int idx, input logic [7:0] d);
      @(negedge clk);
      bd_addr = (PW+7)'(idx); bd_wdata = d; bd_we = 1'b1;
      @(negedge clk) bd_we = 1'b0;
      model[idx] = d;
   endtask

   task automatic bd_check(input int idx, input string req);
      @(negedge clk) bd_addr = (PW+7)'(idx);
      #1 chk(req, bd_rdata, model[idx], "backdoor value");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < PAGES*128; i++) model[i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1: reset state
      chk("R1", miso, 0, "miso after reset");
      bd_check(0, "R1"); bd_check(5, "R1"); bd_check(PAGES*128-1, "R1");
      spi_read(0, 1);

      // R2, R3, R5: write then read back on page 0
      spi_write(7'h12, 8'hA5);
      bd_check(7'h12, "R3");
      spi_read(7'h12, 1);
      spi_write(7'h13, 8'h5A);
      spi_read(7'h12, 2);  // R2: direction bit and offset decode

      // R4: page switch with high bits set in the data byte
      spi_write(0, 8'hFE);
      chk("R4", mpage, 2, "model page");
      spi_read(0, 1);
      spi_write(7'h12, 8'h3C);
      bd_check(2*128 + 7'h12, "R4");
      bd_check(7'h12, "R4");

      // R6: 52-byte burst across the 0x7F -> 0x00 wrap on page 2
      for (int o = 1; o < 128; o++) bd_write(2*128 + o, 8'($urandom));
      spi_read(7'h60, 52);

      // R8: abort a write data byte half way
      sel();
      xbits({7'h20, 1'b0}, 8, r);
      xbits(8'hC3, 4, r);
      desel();
      bd_check(2*128 + 7'h20, "R8");
      spi_write(7'h21, 8'h77);
      bd_check(2*128 + 7'h21, "R8");
      // R8: abort a command byte
      sel(); xbits(8'hFF, 5, r); desel();
      spi_read(7'h21, 1);

      // R9: extra bytes after the write data byte
      sel();
      xbits({7'h30, 1'b0}, 8, r);
      xbits(8'h11, 8, r);
      xbits(8'h22, 8, r);
      chk("R9", r, 0, "miso on ignored byte");
      xbits(8'h33, 8, r);
      desel();
      model[2*128 + 7'h30] = 8'h11;
      bd_check(2*128 + 7'h30, "R9");
      bd_check(2*128 + 7'h31, "R9");

      // R10: backdoor preload then SPI read
      bd_write(2*128 + 7'h40, 8'h9C);
      bd_check(2*128 + 7'h40, "R10");
      spi_read(7'h40, 1);

      // Random mix
      for (int t = 0; t < 60; t++) begin
         int kind;
         kind = int'($urandom % 4);
         case (kind)
            0: begin
               int a;
               a = 1 + int'($urandom % 127);
               spi_write(a, 8'($urandom));
               bd_check(mpage*128 + a, "R3");
            end
            1: spi_read(int'($urandom % 128), 1 + int'($urandom % 6));
            2: begin
               spi_write(0, 8'($urandom));
               spi_read(0, 1);
            end
            default: begin
               int idx;
               idx = int'($urandom % (PAGES*128));
               bd_write(idx, 8'($urandom));
               bd_check(idx, "R10");
            end
         endcase
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule